// File: doc/BRIEF.md
# Charge-Pump Speed-Up Current Controller

This block sits between the serial programming logic and the two charge pumps of a fractional-N PLL. It produces digital current codes for a proportional pump and an integral pump. Each code is a multiplier of a unit current. The block also produces the up/down steering bits that route phase-detector pulses to each pump. The analog current sources take these codes and scale their output. The controller decides the scale, and when the loop runs in its wide-bandwidth acquisition mode.

The block has two modes. In normal mode the proportional pump runs at its unit current and the integral pump is off. Speed-up mode begins when the programming strobe rises while a frequency word is being latched. It ends as soon as the strobe falls. While it lasts, the proportional current is raised by a power of two chosen by a 2-bit gain exponent. The integral pump is switched on at a 4-bit factor times that raised current. Both fields are captured when the strobe rises. All outputs are registered, so every code change appears in the cycle after the strobe edge that caused it, with no intermediate values.

Top module: `spd_pump_ctrl`

## Requirements
- R1: Out of reset, and whenever speed-up mode is inactive, `prop_mult_o` is 1, `int_mult_o` is 0 and `int_en_o` is 0.
- R2: When `strobe_i` is sampled high after being sampled low and `freq_word_i` is 1 at that edge, `boost_o` is 1 in the following cycle.
- R3: A strobe rise with `freq_word_i` at 0 leaves the block in normal mode (`boost_o` 0, codes as in R1).
- R4: In speed-up mode `prop_mult_o` equals 2^(G+1), where G is the captured 2-bit `gain_exp_i`, which gives 2, 4, 8 or 16.
- R5: In speed-up mode `int_mult_o` equals F × 2^(G+1), where F is the captured 4-bit `int_fac_i`. Its largest value is 240.
- R6: In speed-up mode with F = 0, `int_en_o` is 0 and `int_mult_o` is 0. With F > 0, `int_en_o` is 1.
- R7: G and F are taken from the inputs only at the strobe rise. Changes to `gain_exp_i` and `int_fac_i` while the strobe stays high do not alter the output codes.
- R8: The cycle after `strobe_i` is sampled low, `boost_o` is 0 and the codes are back to the R1 values.
- R9: `prop_up_o` and `prop_dn_o` equal `pd_up_i` and `pd_dn_i` as sampled one clock earlier. A 1 on the up bit means source current (raise VCO frequency). A 1 on the down bit means sink current (lower it).
- R10: `int_up_o` and `int_dn_o` copy `pd_up_i` and `pd_dn_i` with one cycle of delay when `int_en_o` is 1 in that cycle. Otherwise they are 0.
- R11: `freq_word_i` rising while the strobe is already high does not start speed-up mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strobe_i | input | 1 | Programming-bus strobe (latch enable) |
| freq_word_i | input | 1 | Word being latched is a frequency word |
| gain_exp_i | input | 2 | Proportional gain exponent G |
| int_fac_i | input | 4 | Integral factor F |
| pd_up_i | input | 1 | Phase-detector up pulse |
| pd_dn_i | input | 1 | Phase-detector down pulse |
| prop_mult_o | output | 5 | Proportional current multiplier |
| int_mult_o | output | 8 | Integral current multiplier |
| int_en_o | output | 1 | Integral pump enable |
| boost_o | output | 1 | Speed-up mode active |
| prop_up_o | output | 1 | Proportional pump source steering |
| prop_dn_o | output | 1 | Proportional pump sink steering |
| int_up_o | output | 1 | Integral pump source steering |
| int_dn_o | output | 1 | Integral pump sink steering |

## Verification
The assertions check several rules on every cycle:
- the normal-mode code values;
- the power-of-two shape of the proportional code;
- the ceiling and ratio of the integral code;
- exit one cycle after the strobe falls;
- the refusal to enter on a non-frequency word or on a late frequency flag;
- that the captured fields stay frozen while the strobe is high;
- the gating of the integral steering.

Only the bench scenarios show that the exact multiplier values match the programmed G and F across the whole field range, including the 240 ceiling and F = 0. They also show that field changes in the middle of a strobe leave the codes unchanged and that back-to-back strobes re-capture fresh fields.

// File: rtl/spd_pkg.sv
package spd_pkg;
    localparam int unsigned GAIN_W_DEF = 2;
    localparam int unsigned FAC_W_DEF  = 4;

    typedef enum logic {
        MODE_NORM  = 1'b0,
        MODE_BOOST = 1'b1
    } spd_mode_e;
endpackage

// File: rtl/spd_mode_fsm.sv
module spd_mode_fsm #(
    parameter int unsigned GAIN_W = spd_pkg::GAIN_W_DEF,
    parameter int unsigned FAC_W  = spd_pkg::FAC_W_DEF
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   strobe_i,
    input  logic                   freq_word_i,
    input  logic [GAIN_W-1:0]      gain_i,
    input  logic [FAC_W-1:0]       fac_i,
    output spd_pkg::spd_mode_e     mode_d_o,
    output logic [GAIN_W-1:0]      gain_d_o,
    output logic [FAC_W-1:0]       fac_d_o,
    output spd_pkg::spd_mode_e     mode_q_o
);
    import spd_pkg::*;

    typedef struct packed {
        logic              strb;
        spd_mode_e         mode;
        logic [GAIN_W-1:0] gain;
        logic [FAC_W-1:0]  fac;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic rise_w;

    always_comb begin
        fsm_d      = fsm_q;
        fsm_d.strb = strobe_i;
        rise_w     = strobe_i & ~fsm_q.strb;
        if (rise_w) begin
            fsm_d.gain = gain_i;
            fsm_d.fac  = fac_i;
            fsm_d.mode = freq_word_i ? MODE_BOOST : MODE_NORM;
        end else if (!strobe_i) begin
            fsm_d.mode = MODE_NORM;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fsm_q <= '{strb: 1'b0, mode: MODE_NORM, gain: '0, fac: '0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign mode_d_o = fsm_d.mode;
    assign gain_d_o = fsm_d.gain;
    assign fac_d_o  = fsm_d.fac;
    assign mode_q_o = fsm_q.mode;

    assert_enter_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (strobe_i && !fsm_q.strb && freq_word_i) |=> (fsm_q.mode == MODE_BOOST));

    assert_skip_other_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (strobe_i && !fsm_q.strb && !freq_word_i) |=> (fsm_q.mode == MODE_NORM));

    assert_no_late_entry_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (strobe_i && fsm_q.strb && fsm_q.mode == MODE_NORM) |=> (fsm_q.mode == MODE_NORM));

    assert_fields_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (strobe_i && fsm_q.strb) |=> ($stable(fsm_q.gain) && $stable(fsm_q.fac)));
endmodule

// File: rtl/spd_gain_calc.sv
module spd_gain_calc #(
    parameter int unsigned GAIN_W = spd_pkg::GAIN_W_DEF,
    parameter int unsigned FAC_W  = spd_pkg::FAC_W_DEF,
    parameter int unsigned PROP_W = (1 << GAIN_W) + 1,
    parameter int unsigned INT_W  = FAC_W + (1 << GAIN_W)
) (
    input  logic              boost_i,
    input  logic [GAIN_W-1:0] gain_i,
    input  logic [FAC_W-1:0]  fac_i,
    output logic [PROP_W-1:0] prop_o,
    output logic [INT_W-1:0]  int_o,
    output logic              int_en_o
);
    localparam int unsigned SH_W = GAIN_W + 1;

    logic [SH_W-1:0] shamt_w;

    always_comb begin
        shamt_w = SH_W'(gain_i) + SH_W'(1);
        if (boost_i) begin
            prop_o   = PROP_W'(1) << shamt_w;
            int_o    = INT_W'(fac_i) << shamt_w;
            int_en_o = (fac_i != '0);
        end else begin
            prop_o   = PROP_W'(1);
            int_o    = '0;
            int_en_o = 1'b0;
        end
    end
endmodule

// File: rtl/spd_steer.sv
module spd_steer #(
    parameter int unsigned N_PUMP = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              up_i,
    input  logic              dn_i,
    input  logic [N_PUMP-1:0] en_i,
    output logic [N_PUMP-1:0] up_o,
    output logic [N_PUMP-1:0] dn_o
);
    for (genvar g = 0; g < N_PUMP; g++) begin : g_pump
        logic up_d, up_q, dn_d, dn_q;

        always_comb begin
            up_d = up_i & en_i[g];
            dn_d = dn_i & en_i[g];
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                up_q <= 1'b0;
                dn_q <= 1'b0;
            end else begin
                up_q <= up_d;
                dn_q <= dn_d;
            end
        end

        assign up_o[g] = up_q;
        assign dn_o[g] = dn_q;

        assert_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !en_i[g] |=> (!up_o[g] && !dn_o[g]));

        assert_follow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            en_i[g] |=> (up_o[g] == $past(up_i) && dn_o[g] == $past(dn_i)));
    end
endmodule

// File: rtl/spd_pump_ctrl.sv
module spd_pump_ctrl #(
    parameter int unsigned GAIN_W = spd_pkg::GAIN_W_DEF,
    parameter int unsigned FAC_W  = spd_pkg::FAC_W_DEF,
    localparam int unsigned PROP_W = (1 << GAIN_W) + 1,
    localparam int unsigned INT_W  = FAC_W + (1 << GAIN_W)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              strobe_i,
    input  logic              freq_word_i,
    input  logic [GAIN_W-1:0] gain_exp_i,
    input  logic [FAC_W-1:0]  int_fac_i,
    input  logic              pd_up_i,
    input  logic              pd_dn_i,
    output logic [PROP_W-1:0] prop_mult_o,
    output logic [INT_W-1:0]  int_mult_o,
    output logic              int_en_o,
    output logic              boost_o,
    output logic              prop_up_o,
    output logic              prop_dn_o,
    output logic              int_up_o,
    output logic              int_dn_o
);
    import spd_pkg::*;

    localparam int unsigned INT_MAX = ((1 << FAC_W) - 1) * (1 << (1 << GAIN_W));

    typedef struct packed {
        logic [PROP_W-1:0] prop;
        logic [INT_W-1:0]  intm;
        logic              int_en;
    } code_t;

    spd_mode_e         mode_d, mode_q;
    logic [GAIN_W-1:0] gain_d;
    logic [FAC_W-1:0]  fac_d;
    logic [PROP_W-1:0] prop_w;
    logic [INT_W-1:0]  int_w;
    logic              int_en_w;
    code_t             code_d, code_q;
    logic [1:0]        steer_en;
    logic [1:0]        steer_up, steer_dn;

    spd_mode_fsm #(.GAIN_W(GAIN_W), .FAC_W(FAC_W)) u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .strobe_i    (strobe_i),
        .freq_word_i (freq_word_i),
        .gain_i      (gain_exp_i),
        .fac_i       (int_fac_i),
        .mode_d_o    (mode_d),
        .gain_d_o    (gain_d),
        .fac_d_o     (fac_d),
        .mode_q_o    (mode_q)
    );

    spd_gain_calc #(.GAIN_W(GAIN_W), .FAC_W(FAC_W), .PROP_W(PROP_W), .INT_W(INT_W)) u_calc (
        .boost_i  (mode_d == MODE_BOOST),
        .gain_i   (gain_d),
        .fac_i    (fac_d),
        .prop_o   (prop_w),
        .int_o    (int_w),
        .int_en_o (int_en_w)
    );

    always_comb begin
        code_d        = code_q;
        code_d.prop   = prop_w;
        code_d.intm   = int_w;
        code_d.int_en = int_en_w;
        steer_en      = {int_en_w, 1'b1};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            code_q <= '{prop: PROP_W'(1), intm: '0, int_en: 1'b0};
        end else begin
            code_q <= code_d;
        end
    end

    spd_steer #(.N_PUMP(2)) u_steer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .up_i   (pd_up_i),
        .dn_i   (pd_dn_i),
        .en_i   (steer_en),
        .up_o   (steer_up),
        .dn_o   (steer_dn)
    );

    assign prop_mult_o = code_q.prop;
    assign int_mult_o  = code_q.intm;
    assign int_en_o    = code_q.int_en;
    assign boost_o     = (mode_q == MODE_BOOST);
    assign prop_up_o   = steer_up[0];
    assign prop_dn_o   = steer_dn[0];
    assign int_up_o    = steer_up[1];
    assign int_dn_o    = steer_dn[1];

    assert_base_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !boost_o |-> (prop_mult_o == PROP_W'(1) && int_mult_o == '0 && !int_en_o));

    assert_pow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        boost_o |-> ($countones(prop_mult_o) == 1 && prop_mult_o >= PROP_W'(2)));

    assert_ratio_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        boost_o |-> (int_mult_o == '0 || int_mult_o >= INT_W'(prop_mult_o)));

    assert_ceiling_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int_mult_o <= INT_W'(INT_MAX));

    assert_kzero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int_en_o == (int_mult_o != '0));

    assert_exit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !strobe_i |=> !boost_o);

    assert_int_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !int_en_o |-> (!int_up_o && !int_dn_o));
endmodule

// File: tb/tb_spd_pump_ctrl.sv
`timescale 1ns/1ps
module tb_spd_pump_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strobe = 1'b0, fw = 1'b0, pd_up = 1'b0, pd_dn = 1'b0;
    logic [1:0] gain = '0;
    logic [3:0] fac = '0;
    logic [4:0] prop_mult;
    logic [7:0] int_mult;
    logic       int_en, boost, p_up, p_dn, i_up, i_dn;

    int checks = 0, errors = 0;
    bit running = 0;

    always #2.5 clk = ~clk;

    spd_pump_ctrl dut (
        .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe), .freq_word_i(fw),
        .gain_exp_i(gain), .int_fac_i(fac), .pd_up_i(pd_up), .pd_dn_i(pd_dn),
        .prop_mult_o(prop_mult), .int_mult_o(int_mult), .int_en_o(int_en),
        .boost_o(boost), .prop_up_o(p_up), .prop_dn_o(p_dn),
        .int_up_o(i_up), .int_dn_o(i_dn)
    );

    // behavioural reference model
    bit m_strb, m_boost;
    int m_g, m_f;
    int e_prop = 1, e_int = 0;
    bit e_en, e_boost, e_pu, e_pd, e_iu, e_id;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_strb <= 0; m_boost <= 0; m_g <= 0; m_f <= 0;
            e_prop <= 1; e_int <= 0; e_en <= 0; e_boost <= 0;
            e_pu <= 0; e_pd <= 0; e_iu <= 0; e_id <= 0;
        end else begin
            automatic bit nb;
            automatic int g = m_g, f = m_f;
            if (strobe && !m_strb) begin
                nb = fw; g = gain; f = fac;
            end else begin
                nb = strobe ? m_boost : 0;
            end
            m_strb <= strobe; m_boost <= nb; m_g <= g; m_f <= f;
            e_boost <= nb;
            e_prop  <= nb ? (2 ** (g + 1)) : 1;
            e_int   <= nb ? f * (2 ** (g + 1)) : 0;
            e_en    <= nb && (f != 0);
            e_pu <= pd_up; e_pd <= pd_dn;
            e_iu <= pd_up && nb && (f != 0);
            e_id <= pd_dn && nb && (f != 0);
        end
    end

    task automatic chk(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (running && rst_n) begin
            chk(boost, e_boost, "R2 boost");
            chk(prop_mult, e_prop, "R4 prop");
            chk(int_mult, e_int, "R5 int");
            chk(int_en, e_en, "R6 int_en");
            chk(p_up, e_pu, "R9 prop_up");
            chk(p_dn, e_pd, "R9 prop_dn");
            chk(i_up, e_iu, "R10 int_up");
            chk(i_dn, e_id, "R10 int_dn");
        end
    end

    task automatic tick();
        @(negedge clk);
        pd_up = 1'($urandom);
        pd_dn = 1'($urandom);
    endtask

    task automatic burst(input bit w, input int g, input int f, input int hold);
        automatic int ep = w ? 2 ** (g + 1) : 1;
        automatic int ei = w ? f * ep : 0;
        strobe = 1; fw = w; gain = 2'(g); fac = 4'(f);
        tick();
        chk(boost, w, w ? "R2 entry" : "R3 other word");
        chk(prop_mult, ep, "R4 prop code");
        chk(int_mult, ei, "R5 int code");
        chk(int_en, (w && f != 0), "R6 int enable");
        gain = ~gain; fac = ~fac; fw = 1;
        repeat (hold) tick();
        chk(boost, w, "R11 late word");
        chk(prop_mult, ep, "R7 held prop");
        chk(int_mult, ei, "R7 held int");
        strobe = 0; fw = 0;
        tick();
        chk(boost, 0, "R8 exit");
        chk(prop_mult, 1, "R8 prop base");
        chk(int_en, 0, "R8 int off");
    endtask

    initial begin
        repeat (4) tick();
        rst_n = 1;
        running = 1;
        tick();
        chk(prop_mult, 1, "R1 reset prop");
        chk(int_mult, 0, "R1 reset int");
        chk(int_en, 0, "R1 reset int_en");
        burst(1, 0, 1, 3);
        burst(1, 3, 15, 4);
        burst(1, 2, 0, 2);
        burst(0, 1, 5, 3);
        burst(1, 1, 7, 1);
        burst(1, 3, 9, 0);
        for (int g = 0; g < 4; g++) begin
            for (int f = 0; f < 16; f += 5) burst(1, g, f, 1);
        end
        for (int i = 0; i < 400; i++) begin
            strobe = 1'($urandom % 3 != 0);
            fw = 1'($urandom);
            gain = 2'($urandom);
            fac = 4'($urandom);
            tick();
        end
        strobe = 0;
        tick();
        chk(boost, 0, "R1 final normal");
        running = 0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(100000 * 5);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule